// File: doc/BRIEF.md
# Feedback-Throttled Greedy Bus Arbiter

This block decides, slot by slot, which of N node interfaces may drive a shared many-to-many bus segment. The bus has no arbitration logic of its own. All access decisions are made by per-node controllers, and a fixed collision rule combines their claims. A node that holds pending work claims the next slot at once, whatever the other nodes are doing. When two or more nodes claim the same slot, the one with the lowest index wins. A node that loses keeps its work and claims again in the next slot.

Over a longer time base, each node limits its own greed. Time is divided into windows of W slots. The last R slots of every window are reserved. Nodes that expect traffic raise a negative-feedback line. At each window boundary, every node reads the summed weight of all raised lines and takes as its budget for the next window its weighted share of the W-R open slots. During open slots a node may claim only while it has budget left. Reserved slots are open to every node with pending work, so an idle node can always start sending.

The slot timer is a two-state machine. `PH_OPEN` covers the budgeted slots 0..W-R-1, and `PH_RESV` covers the reserved slots W-R..W-1. The transition *open-to-reserved* fires on slot W-R-1. The transition *window-wrap* fires on slot W-1 and returns the timer to `PH_OPEN` with the slot index at 0. Budgets are reloaded on the same edge.

Top module: `arb_fbg_top`

## Requirements
- R1: While reset is asserted (rst_n low), and right after reset, no grant is active, every queue count and budget is zero, and the slot index is 0 in state `PH_OPEN`.
- R2: Each node keeps a pending count. A high `enq_i[i]` on a clock edge adds one, unless the count is already QDEPTH, in which case the request is ignored. A grant to the node removes one. Both can happen on the same edge.
- R3: Node i claims a slot when its pending count is nonzero and either its budget is nonzero or the slot is reserved. At most one bit of `grant_o` is high, and it is the lowest-index claimant. A claim that loses leaves the node's count unchanged for the retry in the next slot.
- R4: Slots are numbered 0..W-1 and wrap. Slots W-R..W-1 are reserved. One slot lasts one clock.
- R5: On the edge that ends slot W-1, node i loads its budget with floor((W-R)·weight_i / total), where total is the sum of the weights of the nodes whose `fb_assert_i` bit is high at that edge. The budget is zero if the node's own feedback bit is low, if its pending count is zero, or if the total is zero.
- R6: Outside the window boundary, a node's budget drops by one on a slot it wins while the budget is nonzero. Otherwise the budget is unchanged.
- R7: A node with zero budget receives grants only in reserved slots.
- R8: The 4-bit field `cfg_weight_i[i*WW +: WW]` is node i's weight. Larger weights give proportionally larger budgets.
- R9: `grant_o` depends only on registered state. A request entered on an edge can be granted no earlier than the slot that begins at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slot clock, one slot per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| enq_i | input | N | Per-node request to add one pending transfer |
| fb_assert_i | input | N | Per-node negative-feedback line (expects traffic) |
| cfg_weight_i | input | N*WW | Per-node feedback weight, node i at bits i*WW +: WW |
| grant_o | output | N | One-hot-or-zero grant for the current slot |

## Verification
The slot grants are compared every cycle with a behavioural model. The stimulus starts with a flood with no feedback, where only reserved slots can grant, which separates the reserved-slot rule from budget use. It then applies equal weights and skewed weights (4,2,1,1), which separates proportional budgets from round-robin-like sharing. A single feedback node shows that the whole open share goes to it. A saturating flood on one node exposes overflow of the pending count, and a drain pass exposes budget misuse. A final mixed pattern, with changing requests and changing feedback, exercises collisions and retries at every slot position, including requests that arrive in the slot before a window boundary.

// File: rtl/arb_fbg_pkg.sv
package arb_fbg_pkg;
    typedef enum logic [0:0] {
        PH_OPEN = 1'b0,
        PH_RESV = 1'b1
    } phase_e;
endpackage

// File: rtl/arb_fbg_slot_fsm.sv
module arb_fbg_slot_fsm
    import arb_fbg_pkg::*;
#(
    parameter int W  = 8,
    parameter int R  = 2,
    parameter int SW = $clog2(W)
) (
    input  logic          clk,
    input  logic          rst_n,
    output logic          reserved,
    output logic          window_end,
    output logic [SW-1:0] slot
);
    localparam logic [SW-1:0] LAST_OPEN = SW'(W - R - 1);
    localparam logic [SW-1:0] LAST_SLOT = SW'(W - 1);

    phase_e state, state_nxt;

    always_comb begin
        state_nxt = state;
        unique case (state)
            PH_OPEN: if (slot == LAST_OPEN) state_nxt = PH_RESV;
            PH_RESV: if (slot == LAST_SLOT) state_nxt = PH_OPEN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= PH_OPEN;
            slot  <= '0;
        end else begin
            state <= state_nxt;
            slot  <= (slot == LAST_SLOT) ? '0 : slot + SW'(1);
        end
    end

    always_comb begin
        unique case (state)
            PH_OPEN: begin
                reserved   = 1'b0;
                window_end = 1'b0;
            end
            PH_RESV: begin
                reserved   = 1'b1;
                window_end = (slot == LAST_SLOT);
            end
        endcase
    end
endmodule

// File: rtl/arb_fbg_fb_sum.sv
module arb_fbg_fb_sum #(
    parameter int N  = 4,
    parameter int WW = 4,
    parameter int TW = WW + $clog2(N + 1)
) (
    input  logic [N-1:0]    fb,
    input  logic [N*WW-1:0] weights,
    output logic [TW-1:0]   total
);
    always_comb begin
        total = '0;
        for (int i = 0; i < N; i++) begin
            if (fb[i]) total = total + TW'(weights[i*WW +: WW]);
        end
    end
endmodule

// File: rtl/arb_fbg_node.sv
module arb_fbg_node #(
    parameter int W      = 8,
    parameter int R      = 2,
    parameter int WW     = 4,
    parameter int TW     = 6,
    parameter int QDEPTH = 8,
    parameter int BW     = $clog2(W + 1),
    parameter int QW     = $clog2(QDEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          enq,
    input  logic          fb,
    input  logic [WW-1:0] weight,
    input  logic [TW-1:0] total,
    input  logic          reserved,
    input  logic          window_end,
    input  logic          win,
    output logic          claim,
    output logic [BW-1:0] budget,
    output logic [QW-1:0] qcnt
);
    localparam int PW    = TW + BW + WW;
    localparam int SHARE = W - R;

    logic [PW-1:0] product, quotient;
    logic [BW-1:0] budget_new;
    logic          accept;

    assign product  = PW'(SHARE) * PW'(weight);
    assign quotient = (total == '0) ? '0 : product / PW'(total);
    assign budget_new = (fb && qcnt != '0 && total != '0) ? BW'(quotient) : '0;

    assign claim  = (qcnt != '0) && ((budget != '0) || reserved);
    assign accept = enq && (qcnt != QW'(QDEPTH));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            qcnt <= '0;
        end else begin
            qcnt <= qcnt + QW'(accept) - QW'(win);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            budget <= '0;
        end else if (window_end) begin
            budget <= budget_new;
        end else if (win && budget != '0) begin
            budget <= budget - BW'(1);
        end
    end
endmodule

// File: rtl/arb_fbg_prio.sv
module arb_fbg_prio #(
    parameter int N = 4
) (
    input  logic [N-1:0] claim,
    output logic [N-1:0] grant
);
    always_comb begin
        logic taken;
        taken = 1'b0;
        grant = '0;
        for (int i = 0; i < N; i++) begin
            if (claim[i] && !taken) begin
                grant[i] = 1'b1;
                taken    = 1'b1;
            end
        end
    end
endmodule

// File: rtl/arb_fbg_top.sv
module arb_fbg_top #(
    parameter int N      = 4,
    parameter int W      = 8,
    parameter int R      = 2,
    parameter int WW     = 4,
    parameter int QDEPTH = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [N-1:0]    enq_i,
    input  logic [N-1:0]    fb_assert_i,
    input  logic [N*WW-1:0] cfg_weight_i,
    output logic [N-1:0]    grant_o
);
    localparam int SW = $clog2(W);
    localparam int BW = $clog2(W + 1);
    localparam int QW = $clog2(QDEPTH + 1);
    localparam int TW = WW + $clog2(N + 1);

    logic          reserved, window_end;
    logic [SW-1:0] slot;
    logic [TW-1:0] fb_total;
    logic [N-1:0]  claim;
    logic [N*BW-1:0] budget_flat;
    logic [N*QW-1:0] qcnt_flat;

    arb_fbg_slot_fsm #(.W(W), .R(R), .SW(SW)) u_timer (
        .clk(clk), .rst_n(rst_n), .reserved(reserved),
        .window_end(window_end), .slot(slot)
    );

    arb_fbg_fb_sum #(.N(N), .WW(WW), .TW(TW)) u_fbsum (
        .fb(fb_assert_i), .weights(cfg_weight_i), .total(fb_total)
    );

    for (genvar i = 0; i < N; i++) begin : g_node
        arb_fbg_node #(
            .W(W), .R(R), .WW(WW), .TW(TW), .QDEPTH(QDEPTH), .BW(BW), .QW(QW)
        ) u_node (
            .clk(clk), .rst_n(rst_n),
            .enq(enq_i[i]), .fb(fb_assert_i[i]),
            .weight(cfg_weight_i[i*WW +: WW]), .total(fb_total),
            .reserved(reserved), .window_end(window_end),
            .win(grant_o[i]), .claim(claim[i]),
            .budget(budget_flat[i*BW +: BW]), .qcnt(qcnt_flat[i*QW +: QW])
        );
    end

    arb_fbg_prio #(.N(N)) u_prio (.claim(claim), .grant(grant_o));
endmodule

// File: rtl/arb_fbg_chk.sv
module arb_fbg_chk #(
    parameter int N  = 4,
    parameter int BW = 4,
    parameter int QW = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic [N-1:0]  grant,
    input logic [N-1:0]  claim,
    input logic          reserved,
    input logic          window_end,
    input logic [N*BW-1:0] budget_flat,
    input logic [N*QW-1:0] qcnt_flat
);
    // R3
    grant_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));
    // R3
    grant_lowest_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (grant != '0) |-> ((claim & (grant - N'(1))) == '0) && ((grant & ~claim) == '0));
    // R3
    claim_served_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (claim != '0) |-> (grant != '0));
    // R4
    boundary_reserved_chk: assert property (@(posedge clk) disable iff (!rst_n)
        window_end |-> reserved);
    // R4
    reserved_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(reserved) |-> $past(window_end));

    for (genvar i = 0; i < N; i++) begin : g_chk
        // R7
        open_needs_budget_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (grant[i] && !reserved) |-> (budget_flat[i*BW +: BW] != '0));
        // R6
        budget_spend_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (grant[i] && budget_flat[i*BW +: BW] != '0 && !window_end)
            |=> (budget_flat[i*BW +: BW] == $past(budget_flat[i*BW +: BW]) - BW'(1)));
        // R6
        budget_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (!grant[i] && !window_end) |=> $stable(budget_flat[i*BW +: BW]));
        // R2
        grant_has_work_chk: assert property (@(posedge clk) disable iff (!rst_n)
            grant[i] |-> (qcnt_flat[i*QW +: QW] != '0));
    end
endmodule

bind arb_fbg_top arb_fbg_chk #(.N(N), .BW(BW), .QW(QW)) u_chk (
    .clk(clk), .rst_n(rst_n), .grant(grant_o), .claim(claim),
    .reserved(reserved), .window_end(window_end),
    .budget_flat(budget_flat), .qcnt_flat(qcnt_flat)
);

// File: tb/arb_fbg_top_tb.sv
module arb_fbg_top_tb;
    localparam int N = 4, W = 8, R = 2, WW = 4, QDEPTH = 8;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [N-1:0]    enq = '0;
    logic [N-1:0]    fb = '0;
    logic [N*WW-1:0] wflat = '0;
    logic [N-1:0]    grant;

    int checks = 0;
    int fails  = 0;
    int q[N];
    int bud[N];
    int wts[N];
    int slot = 0;

    arb_fbg_top #(.N(N), .W(W), .R(R), .WW(WW), .QDEPTH(QDEPTH)) u_dut (
        .clk(clk), .rst_n(rst_n), .enq_i(enq), .fb_assert_i(fb),
        .cfg_weight_i(wflat), .grant_o(grant)
    );

    always #10 clk = ~clk;

    function automatic logic [N-1:0] model_grant();
        logic [N-1:0] g = '0;
        for (int i = 0; i < N; i++) begin
            if (q[i] > 0 && (bud[i] > 0 || slot >= W - R)) begin
                g[i] = 1'b1;
                break;
            end
        end
        return g;
    endfunction

    task automatic check(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s slot %0d: grant actual %b expected %b", tag, slot, act, exp);
        end
    endtask

    // Called at a negedge; leaves at the next negedge.
    task automatic tick(input string tag, input logic [N-1:0] e, input logic [N-1:0] f);
        logic [N-1:0] g;
        int total, qpre[N];
        enq = e;
        fb  = f;
        for (int i = 0; i < N; i++) wflat[i*WW +: WW] = WW'(wts[i]);
        #1;
        g = model_grant();
        check(tag, grant, g);
        @(posedge clk);
        total = 0;
        for (int i = 0; i < N; i++) begin
            qpre[i] = q[i];
            if (f[i]) total += wts[i];
        end
        for (int i = 0; i < N; i++) begin
            if (e[i] && qpre[i] < QDEPTH) q[i]++;
            if (g[i]) begin
                q[i]--;
                if (bud[i] > 0) bud[i]--;
            end
        end
        if (slot == W - 1) begin
            for (int i = 0; i < N; i++)
                bud[i] = (f[i] && qpre[i] > 0 && total > 0) ? ((W - R) * wts[i]) / total : 0;
            slot = 0;
        end else begin
            slot++;
        end
        @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: run did not complete, actual hung expected done");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        for (int i = 0; i < N; i++) begin q[i] = 0; bud[i] = 0; wts[i] = 1; end
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1", grant, '0);
        rst_n = 1'b1;
        // R7: flood with no feedback, only reserved slots grant
        for (int k = 0; k < 16; k++) tick("R7", 4'b1111, 4'b0000);
        // R4: equal weights, budgets of one slot each
        for (int k = 0; k < 16; k++) tick("R4", 4'b0000, 4'b1111);
        // R8: skewed weights 4,2,1,1
        wts[0] = 4; wts[1] = 2; wts[2] = 1; wts[3] = 1;
        for (int k = 0; k < 32; k++) tick("R8", 4'b1111, 4'b1111);
        // R5: single feedback node takes the whole open share
        for (int k = 0; k < 24; k++) tick("R5", 4'b0100, 4'b0100);
        // R2: saturating flood on node 3
        for (int k = 0; k < 40; k++) tick("R2", 4'b1000, 4'b1000);
        // R6: drain with equal weights
        wts[0] = 3; wts[1] = 3; wts[2] = 3; wts[3] = 3;
        for (int k = 0; k < 48; k++) tick("R6", 4'b0000, 4'b1111);
        // R9: single pulses on an idle node
        for (int k = 0; k < 24; k++) tick("R9", (k % 5 == 0) ? 4'b0010 : 4'b0000, 4'b0010);
        // R3: mixed collisions and retries
        for (int k = 0; k < 96; k++) tick("R3", 4'(k % 16), 4'((k * 5 + 3) % 16));
        for (int k = 0; k < 32; k++) tick("R3", 4'b0000, 4'b0000);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule